// File: doc/BRIEF.md
# Half-Duplex Line Driver Direction Controller

This block steers the direction-enable pin of an external half-duplex line transceiver from the activity of a UART transmitter. In the automatic mode the pin turns active as soon as a character is announced, so it is already driving when the start bit begins. It stays active for the whole burst and is released either at once when the last stop bit finishes, or after a programmable number of bit times so that the final bits can travel down a long cable. If a new character is announced while that turn-around wait is running, the wait is abandoned and the pin stays active.

A second mode serves addressed multidrop buses. Here the pin follows receive-side address events instead of transmit activity: an address that matches the node's own code turns the pin on, and it stays on whether or not data is being sent. An address that does not match turns it off. A polarity bit selects whether "active" means a high or a low level. When the half-duplex flag is set, a receive-blanking output tells the receiver to drop incoming line data while the transmitter is busy, and this includes the turn-around wait. Mode and polarity are held in shadow registers that only load while the transmitter is idle.

Top module: `xcvr_dir_ctrl`

## Requirements
- R1: While reset is asserted and after its release, with no configuration applied, `line_en` is at its inactive level (high, because polarity resets to 0) and `rx_blank` is low.
- R2: In automatic mode (`dir_mode` = 2'b01), `line_en` becomes active in the cycle after `char_go` is sampled high and stays active until the character's stop bit is reported.
- R3: With `hold_bits` = 0, `line_en` returns to inactive in the cycle after `stop_done` is sampled high, unless `char_go` is high in that same cycle.
- R4: With `hold_bits` = N (1 to 15), `line_en` stays active after `stop_done` and returns to inactive in the cycle after the N-th `bit_tick` that follows it.
- R5: A `char_go` pulse during the turn-around wait cancels the wait, and `line_en` stays active through the new character.
- R6: `act_high` = 1 makes the active level high, and `act_high` = 0 makes it low.
- R7: In latched mode (`dir_mode` = 2'b10), an `addr_seen` pulse with `addr_hit` = 1 makes `line_en` active from the next cycle on, and it stays active regardless of transmit activity.
- R8: In latched mode, an `addr_seen` pulse with `addr_hit` = 0 makes `line_en` inactive from the next cycle on. Leaving latched mode clears the latch.
- R9: `rx_blank` is high exactly when `half_dup` is high and the transmitter is sending a character or running the turn-around wait.
- R10: Changes on `dir_mode` and `act_high` are taken only in a cycle in which the transmitter is idle (not sending and not waiting). While it is busy the previous settings stay in force.
- R11: With `dir_mode` = 2'b00 or 2'b11, `line_en` stays at its inactive level whatever happens on the transmit side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| char_go | input | 1 | Pulse: transmitter is about to send a start bit |
| stop_done | input | 1 | Pulse: the stop bit of the current character has finished |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| hold_bits | input | 4 | Turn-around wait in bit times, 0 means immediate release |
| act_high | input | 1 | Active level of the enable: 1 high, 0 low |
| dir_mode | input | 2 | 01 automatic, 10 latched on address, 00/11 off |
| addr_seen | input | 1 | Pulse: the receive path decoded an address byte |
| addr_hit | input | 1 | Qualifies `addr_seen`: 1 if the address matched the node code |
| half_dup | input | 1 | Enables receive blanking while transmitting |
| line_en | output | 1 | Direction-enable pin for the transceiver |
| rx_blank | output | 1 | High when received line data must be ignored |

## Verification
The hardest situation to reach from the ports is a new character announced during the turn-around wait, combined with a configuration change requested in that same busy window. The stimulus sets a long wait, ends a character, lets some bit ticks pass, and then issues `char_go` while a different mode and polarity are already on the inputs, so that both the cancelled countdown and the deferred shadow load are exercised in one sequence. A behavioural model in the bench tracks the sending, waiting and latched states with plain integers and is compared with both outputs on every clock.

// File: rtl/xcvr_dir_pkg.sv
package xcvr_dir_pkg;
  typedef enum logic [1:0] {
    TXS_IDLE = 2'd0,
    TXS_SEND = 2'd1,
    TXS_HOLD = 2'd2
  } tx_phase_e;

  typedef enum logic [1:0] {
    DM_OFF   = 2'd0,
    DM_AUTO  = 2'd1,
    DM_LATCH = 2'd2,
    DM_RSVD  = 2'd3
  } dir_mode_e;
endpackage

// File: rtl/xcvr_tx_tracker.sv
module xcvr_tx_tracker
  import xcvr_dir_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             char_go,
  input  logic             stop_done,
  input  logic             bit_tick,
  input  logic [DLY_W-1:0] hold_bits,
  output logic             busy
);
  localparam logic [DLY_W-1:0] CNT_ONE  = DLY_W'(1);
  localparam logic [DLY_W-1:0] CNT_ZERO = '0;

  tx_phase_e        phase_q, phase_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (char_go) begin
      phase_d = TXS_SEND;
      cnt_d   = CNT_ZERO;
      cnt_en  = 1'b1;
    end else begin
      unique case (phase_q)
        TXS_SEND: begin
          if (stop_done) begin
            cnt_en = 1'b1;
            if (hold_bits == CNT_ZERO) begin
              phase_d = TXS_IDLE;
              cnt_d   = CNT_ZERO;
            end else begin
              phase_d = TXS_HOLD;
              cnt_d   = hold_bits;
            end
          end
        end
        TXS_HOLD: begin
          if (bit_tick) begin
            cnt_en = 1'b1;
            cnt_d  = cnt_q - CNT_ONE;
            if (cnt_q == CNT_ONE) phase_d = TXS_IDLE;
          end
        end
        default: phase_d = TXS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= TXS_IDLE;
      cnt_q   <= CNT_ZERO;
    end else begin
      phase_q <= phase_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy = (phase_q != TXS_IDLE);

  p_start_send_r2: assert property (@(posedge clk) disable iff (!rst_n)
    char_go |=> (phase_q == TXS_SEND));
  p_zero_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == TXS_SEND && stop_done && !char_go && hold_bits == CNT_ZERO)
      |=> (phase_q == TXS_IDLE));
  p_hold_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == TXS_HOLD) |-> (cnt_q != CNT_ZERO));
  p_hold_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == TXS_HOLD && !bit_tick && !char_go) |=> (phase_q == TXS_HOLD));
  p_cancel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == TXS_HOLD && char_go) |=> (phase_q == TXS_SEND));
endmodule

// File: rtl/xcvr_cfg_shadow.sv
module xcvr_cfg_shadow
  import xcvr_dir_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      busy,
  input  logic [1:0] mode_in,
  input  logic      pol_in,
  output dir_mode_e mode_q,
  output logic      pol_q
);
  logic      load_en;
  dir_mode_e mode_d;

  assign load_en = !busy;
  assign mode_d  = dir_mode_e'(mode_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= DM_OFF;
      pol_q  <= 1'b0;
    end else if (load_en) begin
      mode_q <= mode_d;
      pol_q  <= pol_in;
    end
  end

  p_mode_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));
  p_pol_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pol_q));
endmodule

// File: rtl/xcvr_addr_latch.sv
module xcvr_addr_latch
  import xcvr_dir_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  dir_mode_e mode_q,
  input  logic      addr_seen,
  input  logic      addr_hit,
  output logic      sel_q
);
  logic sel_d;
  logic in_latch;

  assign in_latch = (mode_q == DM_LATCH);

  always_comb begin
    sel_d = sel_q;
    if (!in_latch)      sel_d = 1'b0;
    else if (addr_seen) sel_d = addr_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_d;
  end

  p_hit_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_latch && addr_seen && addr_hit) |=> sel_q);
  p_miss_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_latch && addr_seen && !addr_hit) |=> !sel_q);
  p_quiet_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_latch && !addr_seen) |=> $stable(sel_q));
endmodule

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
  import xcvr_dir_pkg::*;
#(
  parameter int DLY_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             char_go,
  input  logic             stop_done,
  input  logic             bit_tick,
  input  logic [DLY_W-1:0] hold_bits,
  input  logic             act_high,
  input  logic [1:0]       dir_mode,
  input  logic             addr_seen,
  input  logic             addr_hit,
  input  logic             half_dup,
  output logic             line_en,
  output logic             rx_blank
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ok = rst_sync_q[SYNC_STAGES-1];

  logic      busy;
  dir_mode_e mode_q;
  logic      pol_q;
  logic      sel_q;
  logic      drive_on;

  xcvr_tx_tracker #(.DLY_W(DLY_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_ok),
    .char_go   (char_go),
    .stop_done (stop_done),
    .bit_tick  (bit_tick),
    .hold_bits (hold_bits),
    .busy      (busy)
  );

  xcvr_cfg_shadow u_cfg (
    .clk     (clk),
    .rst_n   (rst_ok),
    .busy    (busy),
    .mode_in (dir_mode),
    .pol_in  (act_high),
    .mode_q  (mode_q),
    .pol_q   (pol_q)
  );

  xcvr_addr_latch u_latch (
    .clk       (clk),
    .rst_n     (rst_ok),
    .mode_q    (mode_q),
    .addr_seen (addr_seen),
    .addr_hit  (addr_hit),
    .sel_q     (sel_q)
  );

  always_comb begin
    unique case (mode_q)
      DM_AUTO:  drive_on = busy;
      DM_LATCH: drive_on = sel_q;
      default:  drive_on = 1'b0;
    endcase
  end

  assign line_en  = pol_q ? drive_on : !drive_on;
  assign rx_blank = half_dup && busy;

  p_off_inactive_r11: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_q == DM_OFF || mode_q == DM_RSVD) |-> (line_en == !pol_q));
  p_blank_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    rx_blank |-> half_dup);
  p_auto_follow_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_q == DM_AUTO && char_go) |=> (line_en == pol_q));
endmodule

// File: tb/test_xcvr_dir_ctrl.sv
module test_xcvr_dir_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       char_go = 1'b0, stop_done = 1'b0, bit_tick = 1'b0;
  logic [3:0] hold_bits = 4'd0;
  logic       act_high = 1'b0;
  logic [1:0] dir_mode = 2'b00;
  logic       addr_seen = 1'b0, addr_hit = 1'b0, half_dup = 1'b0;
  logic       line_en, rx_blank;

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";
  bit done = 0;

  xcvr_dir_ctrl i_xcvr_dir_ctrl (
    .clk(clk), .rst_n(rst_n), .char_go(char_go), .stop_done(stop_done),
    .bit_tick(bit_tick), .hold_bits(hold_bits), .act_high(act_high),
    .dir_mode(dir_mode), .addr_seen(addr_seen), .addr_hit(addr_hit),
    .half_dup(half_dup), .line_en(line_en), .rx_blank(rx_blank)
  );

  always #2 clk = ~clk;

  // free-running bit tick, one pulse every 4 cycles
  always @(negedge clk) begin
    cyc <= cyc + 1;
    bit_tick <= ((cyc % 4) == 3);
  end

  // behavioural reference: 0 idle, 1 sending, 2 waiting
  int m_ph = 0, m_cnt = 0, m_mode = 0, m_lat = 0;
  bit m_pol = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_mode = 0; m_pol = 0; m_lat = 0;
    end else begin
      automatic bit was_idle = (m_ph == 0);
      if (m_mode != 2) m_lat = 0;
      else if (addr_seen) m_lat = addr_hit;
      if (char_go) m_ph = 1;
      else if (m_ph == 1 && stop_done) begin
        if (hold_bits == 0) m_ph = 0;
        else begin m_ph = 2; m_cnt = hold_bits; end
      end else if (m_ph == 2 && bit_tick) begin
        if (m_cnt == 1) m_ph = 0;
        m_cnt = m_cnt - 1;
      end
      if (was_idle) begin m_mode = dir_mode; m_pol = act_high; end
    end
  end

  function automatic bit exp_en();
    bit act;
    act = (m_mode == 1) ? (m_ph != 0) : (m_mode == 2) ? (m_lat != 0) : 1'b0;
    return m_pol ? act : !act;
  endfunction

  task automatic chk(input string req, input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk(cur_req, line_en, exp_en(), "line_en");
      chk(cur_req, rx_blank, half_dup && (m_ph != 0), "rx_blank");
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_go();
    @(negedge clk); char_go = 1; @(negedge clk); char_go = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_done = 1; @(negedge clk); stop_done = 0;
  endtask

  task automatic send_char(input int len);
    pulse_go(); cycles(len); pulse_stop();
  endtask

  task automatic addr(input bit hit);
    @(negedge clk); addr_seen = 1; addr_hit = hit;
    @(negedge clk); addr_seen = 0; addr_hit = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cycles(3);
    #1; chk("R1", line_en, 1'b1, "reset line_en");
    chk("R1", rx_blank, 1'b0, "reset rx_blank");
    rst_n = 1;
    cycles(5);
    #1; chk("R1", line_en, 1'b1, "after release line_en");

    // R2 R3: auto, active low, immediate release
    cur_req = "R2"; dir_mode = 2'b01; cycles(2);
    pulse_go();
    #1; chk("R2", line_en, 1'b0, "auto active low after go");
    cycles(6);
    cur_req = "R3"; pulse_stop();
    #1; chk("R3", line_en, 1'b1, "released after stop");
    cycles(3);

    // R4 R6: active high, delay 3
    cur_req = "R6"; act_high = 1; hold_bits = 4'd3; cycles(2);
    #1; chk("R6", line_en, 1'b0, "idle level with high polarity");
    pulse_go();
    #1; chk("R6", line_en, 1'b1, "active high while sending");
    cycles(5);
    cur_req = "R4"; pulse_stop();
    #1; chk("R4", line_en, 1'b1, "held during wait");
    cycles(20);
    #1; chk("R4", line_en, 1'b0, "released after wait");

    // R4 max delay
    hold_bits = 4'd15; send_char(3); cycles(70);
    #1; chk("R4", line_en, 1'b0, "released after 15 bits");

    // R5: cancel during wait, with deferred config (R10)
    cur_req = "R5"; hold_bits = 4'd6; send_char(4); cycles(6);
    cur_req = "R10"; dir_mode = 2'b00; act_high = 0;
    pulse_go();
    #1; chk("R5", line_en, 1'b1, "wait cancelled, still active");
    cycles(5);
    stop_done = 1; char_go = 1; @(negedge clk); stop_done = 0; char_go = 0;
    #1; chk("R3", line_en, 1'b1, "back to back stays active");
    cycles(4); pulse_stop(); cycles(40);
    #1; chk("R10", line_en, 1'b1, "new config applied once idle (off, low pol)");

    // R11: off modes
    cur_req = "R11"; hold_bits = 4'd2; send_char(5); cycles(3);
    #1; chk("R11", line_en, 1'b1, "off mode inactive");
    dir_mode = 2'b11; cycles(2); send_char(3); cycles(12);

    // R7 R8: latched mode
    cur_req = "R7"; dir_mode = 2'b10; act_high = 1; cycles(2);
    addr(1);
    #1; chk("R7", line_en, 1'b1, "latched on hit");
    cycles(5); send_char(3); cycles(20);
    #1; chk("R7", line_en, 1'b1, "latched stays after tx");
    cur_req = "R8"; addr(0);
    #1; chk("R8", line_en, 1'b0, "cleared on miss");
    addr(1); cycles(2); dir_mode = 2'b01; cycles(3);
    #1; chk("R8", line_en, 1'b0, "leaving latched clears");

    // R9: receive blanking
    cur_req = "R9"; half_dup = 1; hold_bits = 4'd4; cycles(2);
    #1; chk("R9", rx_blank, 1'b0, "idle no blank");
    pulse_go();
    #1; chk("R9", rx_blank, 1'b1, "blank while sending");
    cycles(4); pulse_stop();
    #1; chk("R9", rx_blank, 1'b1, "blank during wait");
    cycles(25);
    #1; chk("R9", rx_blank, 1'b0, "blank ends after wait");
    half_dup = 0; send_char(3); cycles(25);
    finish_run();
  end
endmodule